// File: doc/BRIEF.md
# Segmented PCM Sample Compressor

This block turns a 12-bit sign-magnitude linear PCM sample into an 8-bit companded code. Each code holds a sign, a 3-bit segment number that gives the coarse size of the sample, and a 4-bit quantization interval that gives the finer position inside that segment. Large samples lose more low-order precision than small ones, so the dynamic range of 12 bits fits into 8.

The sample arrives with a one-cycle valid strobe. The block counts how many leading zeros the 11-bit magnitude has, up to a limit of seven, and takes the segment as seven minus that count. It then picks the four magnitude bits just below the leading one as the interval and drops every bit below them. A magnitude whose top seven bits are all zero has no implied leading one, so its lowest four bits become the interval directly. The code and its valid strobe come out of a register one clock later.

Top module: `pcm_compressor`

## Requirements
- R1: Field layout. In `in_sample`, bit 11 is the sign and bits 10:0 are the magnitude. In `out_code`, bit 7 is the sign, bits 6:4 are the segment and bits 3:0 are the interval.
- R2: The output sign bit equals the input sign bit, whatever the magnitude.
- R3: The segment equals 7 minus the number of leading zeros in the magnitude, with the count capped at 7. A magnitude with bit 10 set is segment 7. A magnitude whose highest set bit is bit 4 is segment 1.
- R4: For segment s from 1 to 7, the interval is the four magnitude bits just below the leading one, which are bits s+2 down to s-1. All 16 values 0000 to 1111 pass through unchanged.
- R5: When magnitude bits 10:4 are all zero, the segment is 0 and the interval is magnitude bits 3:0.
- R6: The magnitude bits below the interval, which are bits s-2 down to 0 for segment s of 2 or more, have no effect on the code.
- R7: A zero magnitude gives segment 0 and interval 0000 with either sign, and the sign bit is kept.
- R8: `out_valid` is `in_valid` delayed by one clock. The code for a sample taken at one rising edge shows on `out_code` after that edge. Samples can arrive on back-to-back cycles.
- R9: While `in_valid` is low, `out_code` keeps its last value, whatever is on `in_sample`.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_code` to zero at the next rising edge, and it overrides a valid input on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The sample on `in_sample` is taken on this edge |
| in_sample | input | 12 | Sign-magnitude linear sample: sign in bit 11, magnitude in bits 10:0 |
| out_valid | output | 1 | `out_code` holds a new code |
| out_code | output | 8 | Companded code: sign in bit 7, segment in bits 6:4, interval in bits 3:0 |

## Verification
Every result is due exactly one rising edge after its stimulus. A sample that is applied before an edge has its code and valid on the outputs after that edge. A reset that is applied before an edge has cleared the outputs after that edge. The bench changes its inputs on falling edges and reads the outputs on the next falling edge, so each check falls half a period after the single register stage. It never reads the outputs at the edge where they change. In the streaming sweep, the code for each sample is checked on the same falling edge where the next sample is applied, so the sweep confirms the one-cycle latency under back-to-back load. The hold checks change `in_sample` while `in_valid` is low and read `out_code` on each later falling edge.

// File: rtl/pcm_cmp_pkg.sv
package pcm_cmp_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Widths of the code fields; the magnitude width follows from them.
    localparam int SEG_W   = 3;
    localparam int INT_W   = 4;
    localparam int SEG_MAX = (1 << SEG_W) - 1;
    localparam int MAG_W   = SEG_MAX + INT_W;
    localparam int LIN_W   = MAG_W + 1;
    localparam int CODE_W  = 1 + SEG_W + INT_W;

    typedef logic [MAG_W-1:0] mag_t;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [INT_W-1:0] ival_t;

    typedef struct packed {
        logic sign;
        mag_t mag;
    } lin_sample_t;

    typedef struct packed {
        logic  sign;
        seg_t  seg;
        ival_t ival;
    } pcm_code_t;

    // Segment index from a saturated leading-zero count.
    function automatic seg_t seg_from_lz(input seg_t lz);
        return seg_t'(SEG_MAX) - lz;
    endfunction

    // Build the output code word from its fields.
    function automatic pcm_code_t pack_code(input logic sign, input seg_t seg, input ival_t ival);
        pcm_code_t c;
        c.sign = sign;
        c.seg  = seg;
        c.ival = ival;
        return c;
    endfunction
endpackage

// File: rtl/pcm_cmp_lzc.sv
// Counts leading zeros over the top SEG_MAX magnitude bits, saturating at SEG_MAX.
module pcm_cmp_lzc #(
    parameter int MAG_W = pcm_cmp_pkg::MAG_W,
    parameter int SEG_W = pcm_cmp_pkg::SEG_W
) (
    input  logic [MAG_W-1:0] mag,
    output logic [SEG_W-1:0] lz
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SEG_MAX = (1 << SEG_W) - 1;

    logic hit;

    always_comb begin
        lz  = SEG_W'(SEG_MAX);
        hit = 1'b0;
        for (int i = 0; i < SEG_MAX; i++) begin
            if (!hit && mag[MAG_W-1-i]) begin
                lz  = SEG_W'(i);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_cmp_interval_sel.sv
// Chooses the interval bits that sit below the implied leading one of each segment.
module pcm_cmp_interval_sel #(
    parameter int MAG_W = pcm_cmp_pkg::MAG_W,
    parameter int SEG_W = pcm_cmp_pkg::SEG_W,
    parameter int INT_W = pcm_cmp_pkg::INT_W
) (
    input  logic [MAG_W-1:0] mag,
    input  logic [SEG_W-1:0] seg,
    output logic [INT_W-1:0] ival
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NSEG = 1 << SEG_W;

    logic [INT_W-1:0] cand [NSEG];

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        if (s == 0) begin : g_linear
            // no implied one: lowest bits are used directly
            assign cand[s] = mag[INT_W-1:0];
        end else begin : g_scaled
            // leading one at bit s+INT_W-1; interval is the bits below it
            assign cand[s] = mag[s+INT_W-2 : s-1];
        end
    end

    assign ival = cand[seg];
endmodule

// File: rtl/pcm_cmp_out_reg.sv
// Output stage: one register for the code and the strobe, with synchronous reset.
module pcm_cmp_out_reg
    import pcm_cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      nxt_valid,
    input  pcm_code_t nxt_code,
    output logic      q_valid,
    output pcm_code_t q_code
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_code  <= '0;
        end else begin
            q_valid <= nxt_valid;
            if (nxt_valid) begin
                q_code <= nxt_code;
            end
        end
    end
endmodule

// File: rtl/pcm_compressor.sv
module pcm_compressor
    import pcm_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LIN_W-1:0]  in_sample,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);
    timeunit 1ns;
    timeprecision 1ps;

    lin_sample_t smp;
    seg_t        lz;
    seg_t        seg;
    ival_t       ival;
    pcm_code_t   nxt_code;
    pcm_code_t   q_code;

    assign smp = lin_sample_t'(in_sample);

    pcm_cmp_lzc #(.MAG_W(MAG_W), .SEG_W(SEG_W)) lzc_i (
        .mag (smp.mag),
        .lz  (lz)
    );

    assign seg = seg_from_lz(lz);

    pcm_cmp_interval_sel #(.MAG_W(MAG_W), .SEG_W(SEG_W), .INT_W(INT_W)) sel_i (
        .mag  (smp.mag),
        .seg  (seg),
        .ival (ival)
    );

    assign nxt_code = pack_code(smp.sign, seg, ival);

    pcm_cmp_out_reg oreg_i (
        .clk       (clk),
        .rst       (rst),
        .nxt_valid (in_valid),
        .nxt_code  (nxt_code),
        .q_valid   (out_valid),
        .q_code    (q_code)
    );

    assign out_code = q_code;
endmodule

// File: rtl/pcm_compressor_chk.sv
module pcm_compressor_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [11:0] in_sample,
    input logic        out_valid,
    input logic [7:0]  out_code
);
    timeunit 1ns;
    timeprecision 1ps;

    // R10: reset clears both outputs at the next edge
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && out_code == 8'h00));

    // R8: strobe follows input strobe by one clock
    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_latency_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2: sign passes through
    assert_sign_copy_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_code[7] == $past(in_sample[11])));

    // R3: top magnitude bit set gives the highest segment
    assert_top_segment_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample[10]) |=> (out_code[6:4] == 3'd7));

    // R4: interval of the highest segment is the four bits under bit 10
    assert_top_interval_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample[10]) |=> (out_code[3:0] == $past(in_sample[9:6])));

    // R5: small magnitudes are segment 0 with the low bits as interval
    assert_linear_segment_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample[10:4] == 7'd0) |=>
            (out_code[6:0] == {3'd0, $past(in_sample[3:0])}));

    // R7: zero magnitude gives an all-zero code apart from the sign
    assert_zero_mag_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample[10:0] == 11'd0) |=> (out_code[6:0] == 7'd0));

    // R9: code holds while no sample is offered
    assert_hold_code_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_code));
endmodule

bind pcm_compressor pcm_compressor_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/pcm_compressor_tb_top.sv
module pcm_compressor_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = 12'h000;
    logic        out_valid;
    logic [7:0]  out_code;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pcm_compressor dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    // Expected code computed from the requirements.
    function automatic logic [7:0] ref_code(input logic [11:0] s);
        int p = -1;
        for (int i = 10; i >= 0; i--) begin
            if (p < 0 && s[i]) p = i;
        end
        if (p < 4) return {s[11], 3'd0, s[3:0]};
        return {s[11], 3'(p - 3), 4'((s[10:0] >> (p - 4)) & 11'h00F)};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one sample for one cycle and check the result one edge later.
    task automatic send_chk(input string req, input logic [11:0] s);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = s;
        @(negedge clk);
        in_valid  = 1'b0;
        chk({req, " valid"}, {7'd0, out_valid}, 8'd1);
        chk({req, " code"}, out_code, ref_code(s));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {7'd0, out_valid}, 8'd0);
        chk("R10 reset code", out_code, 8'h00);
        rst = 1'b0;
        // reset over a valid sample
        send_chk("R10 prime", 12'h7FF);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_sample = 12'h555;
        @(negedge clk);
        chk("R10 mid valid", {7'd0, out_valid}, 8'd0);
        chk("R10 mid code", out_code, 8'h00);
        rst = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic t_segments();
        // leading one at bit 10..4 gives segments 7..1
        for (int p = 10; p >= 4; p--) begin
            for (int v = 0; v < 16; v++) begin
                logic [11:0] s;
                s = 12'((1 << p) | (v << (p - 4)));
                send_chk("R3 R4 segment", s);
                chk("R4 interval field", {4'd0, out_code[3:0]}, 8'(v));
                chk("R3 segment field", {5'd0, out_code[6:4]}, 8'(p - 3));
            end
        end
    endtask

    task automatic t_seg_zero();
        for (int v = 0; v < 16; v++) begin
            send_chk("R5 linear", 12'(v));
            chk("R5 linear exact", out_code, 8'(v));
        end
    endtask

    task automatic t_zero_mag();
        send_chk("R7 zero pos", 12'h000);
        chk("R7 zero pos exact", out_code, 8'h00);
        send_chk("R7 zero neg", 12'h800);
        chk("R7 zero neg exact", out_code, 8'h80);
    endtask

    task automatic t_sign();
        send_chk("R2 sign pos", 12'h2B7);
        chk("R2 sign bit pos", {7'd0, out_code[7]}, 8'd0);
        send_chk("R2 sign neg", 12'hAB7);
        chk("R2 sign bit neg", {7'd0, out_code[7]}, 8'd1);
        // R1: field layout of a known sample: 0x2B7 -> seg 6, interval 0101
        chk("R1 layout", {1'b1, out_code[6:0]}, 8'hE5);
    endtask

    task automatic t_dropped();
        // segment 7: bits 5..0 dropped; interval 1010
        for (int low = 0; low < 64; low += 9) begin
            send_chk("R6 drop", 12'(11'h680 | low));
            chk("R6 drop exact", out_code, 8'h7A);
        end
        // segment 2: bit 0 dropped
        send_chk("R6 drop s2 a", 12'h02C);
        chk("R6 drop s2 a exact", out_code, 8'h26);
        send_chk("R6 drop s2 b", 12'h02D);
        chk("R6 drop s2 b exact", out_code, 8'h26);
    endtask

    task automatic t_hold();
        send_chk("R9 prime", 12'h9F0);
        for (int k = 0; k < 4; k++) begin
            in_sample = 12'(12'h123 * (k + 3));
            @(negedge clk);
            chk("R9 hold code", out_code, ref_code(12'h9F0));
            chk("R8 idle valid", {7'd0, out_valid}, 8'd0);
        end
    endtask

    task automatic t_sweep();
        @(negedge clk);
        for (int i = 0; i <= 4096; i++) begin
            if (i > 0) begin
                chk("R8 stream valid", {7'd0, out_valid}, 8'd1);
                chk("R1 stream code", out_code, ref_code(12'(i - 1)));
            end
            if (i < 4096) begin
                in_valid  = 1'b1;
                in_sample = 12'(i);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 stream end", {7'd0, out_valid}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_segments();
        t_seg_zero();
        t_zero_mag();
        t_sign();
        t_dropped();
        t_hold();
        t_sweep();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule